// File: doc/BRIEF.md
# Packet buffer memory manager

This block keeps track of a small pool of packet pages (four pages of 2048 bytes by default) for a byte-wide Ethernet controller. It records which pages are in use, holds three queues of page numbers (frames waiting to go out, frames already sent, frames received), and exposes an interrupt status word with mask, acknowledge and a single level-sensitive interrupt line. The page contents, the MAC and the PHY live elsewhere; only page numbers pass through here.

The host drives it with byte-wide register writes. A write to the command register carries a 3-bit operation code in bits 7:5, and each operation completes in the clock cycle of the write. A frame writer on the receive side asks for a page and, when granted, gets its number pushed onto the receive queue. On the transmit side the head of the transmit queue is presented to a transmitter, which pulses a sent strobe when it is done with it.

A transmit allocation that finds no free page is remembered. The allocator state machine has three named states: `AL_IDLE` (nothing requested since reset or manager reset, result reads 0x00), `AL_PEND` (request outstanding, result reads 0x80) and `AL_HELD` (result reads the page). Its transitions are: *request-hit* (IDLE/HELD to HELD when the allocate command finds a page), *request-miss* (IDLE/HELD to PEND when none is free), *retry-hit* (PEND to HELD in the first cycle a page becomes free, including a page released in that same cycle) and *manager-reset* (any state to IDLE).

Top module: `pktmem_mgr`

## Requirements
- R1: After reset the interrupt status reads 0x04, the mask reads 0x00, the allocation result reads 0x00, both queue-head registers read 0x80, the page-use count reads 0, and irq, tx_valid and rx_grant are low.
- R2: An allocation always takes the lowest-numbered free page; register select 7 reads the number of pages currently in use.
- R3: Command code 1 (bits 7:5 of a write to select 0) allocates a page for transmit: on success the result register (select 2) reads the page number and status bit 3 is set; when all pages are in use the result reads 0x80 and status bit 3 is clear.
- R4: While the result reads 0x80, the first cycle in which a page is freed (command 5 releasing the page in the packet-number register, select 1) hands that page to the pending allocation, so the result reads it and status bit 3 is set.
- R5: Command code 2 frees every page, empties all three queues and returns the result register to 0x00.
- R6: A receive request is granted combinationally with rx_page set to the lowest free page, which is pushed onto the receive queue and sets status bit 0; it is refused when all pages are in use, when the receive queue holds four entries, or when a transmit allocation takes a page in the same cycle.
- R7: Command code 3 removes the receive-queue head and shifts the rest forward; command 4 also frees the head page first. Afterwards status bit 0 is 1 if entries remain and 0 otherwise; on an empty queue both leave it empty.
- R8: Command code 6 appends the low page-number bits of the packet-number register to the transmit queue unless it already holds four entries; tx_valid and tx_page show its head, and tx_sent pops it.
- R9: When a page is sent with auto_release high its page is freed; otherwise its number is appended to the completion queue, provided that queue holds fewer than four entries.
- R10: Command code 7 empties the transmit queue and the completion queue and leaves pages untouched.
- R11: Status bit 2 is 1 whenever the transmit queue is empty and bit 1 is 1 whenever the completion queue is not empty; outside those cases they hold until acknowledged.
- R12: Writing v to select 5 clears the status bits set in v AND 0xD6; if bit 1 of v is set the completion-queue head (read at select 3) is also removed.
- R13: irq is high exactly when status AND mask (mask written and read at select 6) is nonzero.
- R14: Register selects: 0 command (reads 0), 1 packet number, 2 allocation result, 3 completion head, 4 receive head, 5 status/acknowledge, 6 mask, 7 page-use count; writes to selects 2, 3, 4 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| auto_release | input | 1 | Free pages as they are sent instead of reporting them |
| irq | output | 1 | Level interrupt, status AND mask nonzero |
| rx_req | input | 1 | Frame writer requests a page |
| rx_grant | output | 1 | Request accepted this cycle |
| rx_page | output | $clog2(NPAGES) | Page granted to the frame writer |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_page | output | $clog2(NPAGES) | Page at the transmit-queue head |
| tx_sent | input | 1 | Transmitter finished the head page |

## Verification
The hardest situation to reach is a pending transmit allocation meeting a release: every page must first be taken, an allocate must fail, and only then a release of a chosen page may occur. The stimulus fills the pool, then for each page in turn provokes a failed allocate and releases exactly that page, so the retry must land on it. A second hard case is a receive request colliding with a transmit allocate in the same cycle, which the bench drives by raising rx_req together with the command write and sampling the grant before the edge.

// File: rtl/pktmem_pkg.sv
`timescale 1ns/1ps
package pktmem_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_TX_ALLOC  = 3'd1,
        CMD_MMU_RESET = 3'd2,
        CMD_RX_POP    = 3'd3,
        CMD_RX_FREE   = 3'd4,
        CMD_PAGE_FREE = 3'd5,
        CMD_TX_QUEUE  = 3'd6,
        CMD_TX_FLUSH  = 3'd7
    } mmu_cmd_e;

    typedef enum logic [1:0] {
        AL_IDLE = 2'd0,
        AL_PEND = 2'd1,
        AL_HELD = 2'd2
    } alloc_state_e;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_PKT    = 3'd1;
    localparam logic [2:0] SEL_RESULT = 3'd2;
    localparam logic [2:0] SEL_DONE   = 3'd3;
    localparam logic [2:0] SEL_RXHEAD = 3'd4;
    localparam logic [2:0] SEL_IRQ    = 3'd5;
    localparam logic [2:0] SEL_MASK   = 3'd6;
    localparam logic [2:0] SEL_USAGE  = 3'd7;

    localparam int IRQ_RX      = 0;
    localparam int IRQ_TXDONE  = 1;
    localparam int IRQ_TXEMPTY = 2;
    localparam int IRQ_ALLOC   = 3;

    localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
    localparam logic [7:0] NONE_CODE     = 8'h80;
    localparam logic [7:0] STAT_RESET    = 8'h04;

endpackage

// File: rtl/pm_queue.sv
`timescale 1ns/1ps
module pm_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next,
    output logic          empty,
    output logic          full
);

    logic [DEPTH*W-1:0] slots_q, slots_d;
    logic [CW-1:0]      cnt_q, cnt_mid;
    logic               do_pop, do_push;

    assign do_pop = pop && (cnt_q != '0);

    always_comb begin
        cnt_mid = do_pop ? cnt_q - 1'b1 : cnt_q;
        do_push = push && (cnt_mid < CW'(DEPTH));
        slots_d = do_pop ? (slots_q >> W) : slots_q;
        if (do_push) begin
            slots_d[int'(cnt_mid)*W +: W] = push_data;
        end
        if (clr) begin
            count_next = '0;
        end else begin
            count_next = cnt_mid + CW'(do_push);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            cnt_q   <= '0;
        end else begin
            slots_q <= clr ? '0 : slots_d;
            cnt_q   <= count_next;
        end
    end

    assign head  = slots_q[W-1:0];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    assert_empty_pop_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty);

endmodule

// File: rtl/pm_page_pool.sv
`timescale 1ns/1ps
module pm_page_pool #(
    parameter int NPAGES = 4,
    localparam int PW    = $clog2(NPAGES),
    localparam int UW    = $clog2(NPAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NPAGES-1:0] rel_mask,
    input  logic              take,
    output logic              free_any,
    output logic [PW-1:0]     free_idx,
    output logic [UW-1:0]     used_cnt
);

    logic [NPAGES-1:0] map_q, kept, avail;

    assign kept  = map_q & ~rel_mask;
    assign avail = ~kept;
    assign free_any = |avail;

    always_comb begin
        free_idx = '0;
        for (int i = NPAGES - 1; i >= 0; i--) begin
            if (avail[i]) free_idx = PW'(i);
        end
    end

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < NPAGES; i++) begin
            used_cnt = used_cnt + UW'(map_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (clr) begin
            map_q <= '0;
        end else begin
            map_q <= kept | (take ? (NPAGES'(1) << free_idx) : '0);
        end
    end

    assert_take_only_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> free_any);

    assert_take_marks_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> map_q[$past(free_idx)]);

endmodule

// File: rtl/pktmem_mgr.sv
`timescale 1ns/1ps
module pktmem_mgr
    import pktmem_pkg::*;
#(
    parameter int NPAGES = 4,
    parameter int QDEPTH = NPAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [2:0]                reg_sel,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic                      auto_release,
    output logic                      irq,
    input  logic                      rx_req,
    output logic                      rx_grant,
    output logic [$clog2(NPAGES)-1:0] rx_page,
    output logic                      tx_valid,
    output logic [$clog2(NPAGES)-1:0] tx_page,
    input  logic                      tx_sent
);

    localparam int PW = $clog2(NPAGES);
    localparam int CW = $clog2(QDEPTH + 1);
    localparam int UW = $clog2(NPAGES + 1);

    // ---------------- register decode ----------------
    logic     cmd_fire, ack_fire, mask_fire, pkt_fire;
    mmu_cmd_e cmd;
    logic     do_alloc, do_mmu_rst, do_rx_pop, do_rx_free;
    logic     do_page_free, do_tx_queue, do_tx_flush;

    assign cmd_fire  = reg_wr && (reg_sel == SEL_CMD);
    assign pkt_fire  = reg_wr && (reg_sel == SEL_PKT);
    assign ack_fire  = reg_wr && (reg_sel == SEL_IRQ);
    assign mask_fire = reg_wr && (reg_sel == SEL_MASK);
    assign cmd       = mmu_cmd_e'(reg_wdata[7:5]);

    assign do_alloc     = cmd_fire && (cmd == CMD_TX_ALLOC);
    assign do_mmu_rst   = cmd_fire && (cmd == CMD_MMU_RESET);
    assign do_rx_pop    = cmd_fire && (cmd == CMD_RX_POP);
    assign do_rx_free   = cmd_fire && (cmd == CMD_RX_FREE);
    assign do_page_free = cmd_fire && (cmd == CMD_PAGE_FREE);
    assign do_tx_queue  = cmd_fire && (cmd == CMD_TX_QUEUE);
    assign do_tx_flush  = cmd_fire && (cmd == CMD_TX_FLUSH);

    // ---------------- state registers ----------------
    logic [7:0]   pkt_q, stat_q, stat_d, mask_q;
    alloc_state_e state_q, state_d;
    logic [PW-1:0] held_q, held_d;
    logic [PW-1:0] pkt_page;

    assign pkt_page = pkt_q[PW-1:0];

    // ---------------- queues and pool ----------------
    logic          free_any, tx_take, pool_take, sent_ok;
    logic [PW-1:0] free_idx;
    logic [UW-1:0] used_cnt;
    logic [NPAGES-1:0] rel_mask;

    logic [PW-1:0] rxq_head, txq_head, dnq_head;
    logic [CW-1:0] rxq_cnt, txq_cnt, dnq_cnt;
    logic [CW-1:0] rxq_nxt, txq_nxt, dnq_nxt;
    logic          rxq_empty, rxq_full, txq_empty, txq_full, dnq_empty, dnq_full;

    assign sent_ok = tx_sent && !txq_empty;

    always_comb begin
        rel_mask = '0;
        if (do_rx_free && !rxq_empty) rel_mask = rel_mask | (NPAGES'(1) << rxq_head);
        if (do_page_free)             rel_mask = rel_mask | (NPAGES'(1) << pkt_page);
        if (sent_ok && auto_release)  rel_mask = rel_mask | (NPAGES'(1) << txq_head);
    end

    assign tx_take   = !do_mmu_rst && (do_alloc || (state_q == AL_PEND)) && free_any;
    assign rx_grant  = rx_req && !do_mmu_rst && !tx_take && free_any && !rxq_full;
    assign rx_page   = free_idx;
    assign pool_take = tx_take || rx_grant;

    pm_page_pool #(.NPAGES(NPAGES)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (do_mmu_rst),
        .rel_mask (rel_mask),
        .take     (pool_take),
        .free_any (free_any),
        .free_idx (free_idx),
        .used_cnt (used_cnt)
    );

    pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (do_mmu_rst),
        .push       (rx_grant),
        .push_data  (free_idx),
        .pop        (do_rx_pop || do_rx_free),
        .head       (rxq_head),
        .count      (rxq_cnt),
        .count_next (rxq_nxt),
        .empty      (rxq_empty),
        .full       (rxq_full)
    );

    pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (do_mmu_rst || do_tx_flush),
        .push       (do_tx_queue),
        .push_data  (pkt_page),
        .pop        (sent_ok),
        .head       (txq_head),
        .count      (txq_cnt),
        .count_next (txq_nxt),
        .empty      (txq_empty),
        .full       (txq_full)
    );

    pm_queue #(.DEPTH(QDEPTH), .W(PW)) u_dnq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (do_mmu_rst || do_tx_flush),
        .push       (sent_ok && !auto_release),
        .push_data  (txq_head),
        .pop        (ack_fire && reg_wdata[IRQ_TXDONE]),
        .head       (dnq_head),
        .count      (dnq_cnt),
        .count_next (dnq_nxt),
        .empty      (dnq_empty),
        .full       (dnq_full)
    );

    assign tx_valid = !txq_empty;
    assign tx_page  = txq_head;

    // ---------------- allocator state machine ----------------
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            AL_IDLE, AL_HELD: begin
                if (do_alloc) state_d = free_any ? AL_HELD : AL_PEND;
            end
            AL_PEND: begin
                if (free_any) state_d = AL_HELD;
            end
            default: state_d = AL_IDLE;
        endcase
        if (tx_take)    held_d  = free_idx;
        if (do_mmu_rst) state_d = AL_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AL_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // ---------------- interrupt status ----------------
    always_comb begin
        stat_d = stat_q;
        if (ack_fire) stat_d = stat_d & ~(reg_wdata & ACK_CLEARABLE);
        if (do_alloc) stat_d[IRQ_ALLOC] = 1'b0;
        if (tx_take)  stat_d[IRQ_ALLOC] = 1'b1;
        if (do_rx_pop || do_rx_free) stat_d[IRQ_RX] = (rxq_nxt != '0);
        if (rx_grant) stat_d[IRQ_RX] = 1'b1;
        if (txq_nxt == '0) stat_d[IRQ_TXEMPTY] = 1'b1;
        if (dnq_nxt != '0) stat_d[IRQ_TXDONE]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RESET;
            mask_q <= '0;
            pkt_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (mask_fire) mask_q <= reg_wdata;
            if (pkt_fire)  pkt_q  <= reg_wdata;
        end
    end

    assign irq = |(stat_q & mask_q);

    // ---------------- read mux ----------------
    always_comb begin
        unique case (reg_sel)
            SEL_CMD:    reg_rdata = 8'h00;
            SEL_PKT:    reg_rdata = pkt_q;
            SEL_RESULT: reg_rdata = (state_q == AL_IDLE) ? 8'h00 :
                                    (state_q == AL_PEND) ? NONE_CODE : 8'(held_q);
            SEL_DONE:   reg_rdata = dnq_empty ? NONE_CODE : 8'(dnq_head);
            SEL_RXHEAD: reg_rdata = rxq_empty ? NONE_CODE : 8'(rxq_head);
            SEL_IRQ:    reg_rdata = stat_q;
            SEL_MASK:   reg_rdata = mask_q;
            default:    reg_rdata = 8'(used_cnt);
        endcase
    end

    // ---------------- assertions ----------------
    assert_txempty_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty |-> stat_q[IRQ_TXEMPTY]);

    assert_txdone_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dnq_empty |-> stat_q[IRQ_TXDONE]);

    assert_alloc_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[IRQ_ALLOC]) |-> (state_q == AL_HELD));

    assert_grant_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant |-> (!rxq_full && free_any && !tx_take));

    assert_retry_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AL_PEND && free_any && !do_mmu_rst) |=> (state_q == AL_HELD));

    assert_reset_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_mmu_rst |=> (state_q == AL_IDLE && rxq_empty && txq_empty && dnq_empty));

endmodule

// File: tb/pktmem_mgr_tb.sv
`timescale 1ns/1ps
module pktmem_mgr_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       auto_release = 1'b0;
    logic       irq;
    logic       rx_req = 1'b0;
    logic       rx_grant;
    logic [1:0] rx_page;
    logic       tx_valid;
    logic [1:0] tx_page;
    logic       tx_sent = 1'b0;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    pktmem_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .auto_release(auto_release),
        .irq(irq), .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
        .tx_valid(tx_valid), .tx_page(tx_page), .tx_sent(tx_sent)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] s, input logic [7:0] exp);
        logic [7:0] v;
        rd(s, v);
        chk(tag, v, exp);
    endtask

    task automatic send();
        @(negedge clk);
        tx_sent = 1'b1;
        @(negedge clk);
        tx_sent = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, v0;
        logic [1:0] order [4];
        order = '{2'd2, 2'd1, 2'd3, 2'd0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 status", 3'd5, 8'h04);
        rdchk("R1 mask", 3'd6, 8'h00);
        rdchk("R1 result", 3'd2, 8'h00);
        rdchk("R1 done head", 3'd3, 8'h80);
        rdchk("R1 rx head", 3'd4, 8'h80);
        rdchk("R1 usage", 3'd7, 8'h00);
        chk("R1 irq/tx_valid/rx_grant", {5'd0, irq, tx_valid, rx_grant}, 8'h00);
        rdchk("R14 command reads 0", 3'd0, 8'h00);

        // R2/R3 fill the pool
        for (int i = 0; i < 4; i++) begin
            wr(3'd0, 8'h20);
            rdchk("R3 alloc result", 3'd2, 8'(i));
            rd(3'd5, v); chk("R3 alloc bit set", v & 8'h08, 8'h08);
            rdchk("R2 usage count", 3'd7, 8'(i + 1));
        end
        wr(3'd0, 8'h20);
        rdchk("R3 failed alloc", 3'd2, 8'h80);
        rd(3'd5, v); chk("R3 alloc bit clear", v & 8'h08, 8'h00);

        // R4 retry lands on each released page
        for (int p = 0; p < 4; p++) begin
            wr(3'd1, 8'(p));
            wr(3'd0, 8'hA0);
            rdchk("R4 retry result", 3'd2, 8'(p));
            rd(3'd5, v); chk("R4 retry alloc bit", v & 8'h08, 8'h08);
            rdchk("R4 usage stays full", 3'd7, 8'h04);
            wr(3'd0, 8'h20);
            rdchk("R4 pending again", 3'd2, 8'h80);
        end

        // R5 manager reset
        wr(3'd0, 8'h40);
        rdchk("R5 result", 3'd2, 8'h00);
        rdchk("R5 usage", 3'd7, 8'h00);

        // R2 lowest free after a hole
        wr(3'd0, 8'h20); wr(3'd0, 8'h20); wr(3'd0, 8'h20);
        wr(3'd1, 8'h01); wr(3'd0, 8'hA0);
        rdchk("R2 usage after free", 3'd7, 8'h02);
        wr(3'd0, 8'h20);
        rdchk("R2 lowest free chosen", 3'd2, 8'h01);
        wr(3'd0, 8'h20);
        rdchk("R2 next free chosen", 3'd2, 8'h03);

        // R6 receive side
        wr(3'd0, 8'h40);
        wr(3'd6, 8'h01);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_req = 1'b1;
            #1;
            chk("R6 grant", {7'd0, rx_grant}, 8'h01);
            chk("R6 page", {6'd0, rx_page}, 8'(i));
            @(negedge clk);
            rx_req = 1'b0;
        end
        @(negedge clk);
        rx_req = 1'b1;
        #1 chk("R6 refused when full", {7'd0, rx_grant}, 8'h00);
        @(negedge clk);
        rx_req = 1'b0;
        rdchk("R6 rx head", 3'd4, 8'h00);
        rd(3'd5, v); chk("R6 rx bit", v & 8'h01, 8'h01);
        chk("R13 irq on rx", {7'd0, irq}, 8'h01);

        // R7 pops
        wr(3'd0, 8'h60);
        rdchk("R7 pop shifts", 3'd4, 8'h01);
        rd(3'd5, v); chk("R7 bit stays", v & 8'h01, 8'h01);
        wr(3'd0, 8'h80);
        rdchk("R7 free+pop head", 3'd4, 8'h02);
        rdchk("R7 free usage", 3'd7, 8'h03);
        wr(3'd0, 8'h80);
        wr(3'd0, 8'h80);
        rdchk("R7 queue empty", 3'd4, 8'h80);
        rdchk("R7 usage after frees", 3'd7, 8'h01);
        rd(3'd5, v); chk("R7 bit cleared", v & 8'h01, 8'h00);
        chk("R13 irq dropped", {7'd0, irq}, 8'h00);
        wr(3'd0, 8'h60);
        rdchk("R7 pop on empty", 3'd4, 8'h80);

        // R6 collision with transmit allocate
        wr(3'd0, 8'h40);
        @(negedge clk);
        rx_req = 1'b1; reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 8'h20;
        #1 chk("R6 refused on tx alloc", {7'd0, rx_grant}, 8'h00);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R6 grant after", {7'd0, rx_grant}, 8'h01);
        chk("R6 grant page", {6'd0, rx_page}, 8'h01);
        @(negedge clk);
        rx_req = 1'b0;
        rdchk("R6 tx took page 0", 3'd2, 8'h00);
        rdchk("R6 usage 2", 3'd7, 8'h02);

        // R8/R11 transmit queue
        wr(3'd0, 8'h40);
        wr(3'd1, 8'h02); wr(3'd0, 8'hC0);
        chk("R8 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R8 tx_page", {6'd0, tx_page}, 8'h02);
        wr(3'd5, 8'h04);
        rd(3'd5, v); chk("R11 empty bit ackable", v & 8'h04, 8'h00);
        wr(3'd1, 8'h01); wr(3'd0, 8'hC0);
        wr(3'd1, 8'h03); wr(3'd0, 8'hC0);
        wr(3'd1, 8'h00); wr(3'd0, 8'hC0);
        wr(3'd1, 8'h01); wr(3'd0, 8'hC0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1 chk("R8 head order", {6'd0, tx_page}, {6'd0, order[i]});
            send();
        end
        #1 chk("R8 fifth ignored", {7'd0, tx_valid}, 8'h00);
        rd(3'd5, v); chk("R11 empty and done bits", v & 8'h06, 8'h06);

        // R12 completion drain
        rdchk("R9 done head", 3'd3, 8'h02);
        for (int i = 1; i < 4; i++) begin
            wr(3'd5, 8'h02);
            rdchk("R12 done pop", 3'd3, {6'd0, order[i]});
        end
        wr(3'd5, 8'h02);
        rdchk("R12 done empty", 3'd3, 8'h80);
        rd(3'd5, v); chk("R12 done bit cleared", v & 8'h02, 8'h00);
        wr(3'd0, 8'h20);
        rd(3'd5, v0);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); chk("R12 ack mask D6", v, (v0 & 8'h29) | 8'h04);

        // R9 auto release
        wr(3'd0, 8'h40);
        wr(3'd0, 8'h20);
        wr(3'd1, 8'h00); wr(3'd0, 8'hC0);
        auto_release = 1'b1;
        send();
        auto_release = 1'b0;
        rdchk("R9 auto freed", 3'd7, 8'h00);
        rdchk("R9 not reported", 3'd3, 8'h80);

        // R9 completion queue cap
        for (int i = 0; i < 4; i++) begin
            wr(3'd1, 8'(i)); wr(3'd0, 8'hC0);
        end
        for (int i = 0; i < 4; i++) send();
        wr(3'd1, 8'h01); wr(3'd0, 8'hC0);
        send();
        for (int i = 0; i < 4; i++) begin
            rdchk("R9 capped done order", 3'd3, 8'(i));
            wr(3'd5, 8'h02);
        end
        rdchk("R9 fifth dropped", 3'd3, 8'h80);

        // R10 flush
        wr(3'd1, 8'h02); wr(3'd0, 8'hC0);
        wr(3'd1, 8'h03); wr(3'd0, 8'hC0);
        send();
        rdchk("R10 pre done", 3'd3, 8'h02);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'hE0);
        #1 chk("R10 tx cleared", {7'd0, tx_valid}, 8'h00);
        rdchk("R10 done cleared", 3'd3, 8'h80);
        rdchk("R10 pages kept", 3'd7, 8'h01);

        // R14 writes to read-only selects
        rd(3'd2, v0);
        wr(3'd2, 8'h55);
        rdchk("R14 result unchanged", 3'd2, v0);
        wr(3'd7, 8'h33);
        rdchk("R14 usage unchanged", 3'd7, 8'h01);
        wr(3'd1, 8'h5A);
        rdchk("R14 packet number", 3'd1, 8'h5A);

        // R13 mask sweep
        rd(3'd5, v0);
        for (int m = 0; m < 256; m++) begin
            wr(3'd6, 8'(m));
            #1 chk("R13 irq", {7'd0, irq}, {7'd0, ((v0 & 8'(m)) != 8'h00)});
            rdchk("R13 mask readback", 3'd6, 8'(m));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule